// File: doc/BRIEF.md
# Byte-Accessed Capture/Compare Timer

A 16-bit counter runs freely from reset, advancing one step per clock. Two input-capture channels watch external pins and, on a rising edge, copy the counter into their own 16-bit capture register and raise their own event flag. A compare unit raises a third flag when the counter reaches a programmed 16-bit value. A small processor reaches all of this through an 8-bit register bus, so every 16-bit quantity is moved as two bytes. Byte-ordering rules keep those 16-bit values coherent.

All three flags feed a single interrupt line through per-flag enables. The interrupt handler reads the status register to find which event fired. A flag is released by a two-step handshake: first a status read while the flag is up, then an access to the low byte of the register that belongs to that event. An event that arrives during the handshake keeps its flag standing, so it is never lost.

Top module: `capcmp_timer`

## Requirements
- R1: After reset all three flags read 0, the enable register reads 0, `irq_o` is low, and the compare unit is disabled. No compare flag is raised before both compare bytes have been written.
- R2: The counter starts at 0 and increases by one every clock. A read of the counter high byte returns bits 15:8 and freezes bits 7:0 of that same value. The next read of the counter low byte returns the frozen byte.
- R3: A rising edge on `cap_i[n]` copies the counter value of that clock into capture register n and sets status bit n.
- R4: A read of a capture high byte freezes the low byte of the same sample. A later read of that channel's low byte returns the frozen byte, even if a new capture has occurred in between.
- R5: A flag clears only after two steps. First, the status register is read while the flag is set. Then comes a read of that channel's capture low byte (for capture flags) or a write of the compare low byte (for the compare flag). A low-byte access without the earlier status read leaves the flag set.
- R6: If a new event for a flag arrives after the status read and before the low-byte access, that access leaves the flag set. Clearing it then needs a fresh status read.
- R7: If an event and the clearing low-byte access fall in the same clock, the flag stays set.
- R8: The compare flag (status bit 2) is set at the clock edge at which the counter equals the full 16-bit compare value. It is not visible before that edge.
- R9: A write of the compare high byte disables matching. Matching resumes only after the compare low byte is written, so a match on a half-written value is never taken.
- R10: `irq_o` is high exactly when at least one flag is set and its enable bit is set. Enable bit positions are the same as the status bit positions.
- R11: Register map, byte addresses on `addr_i`: 0 status (bits 0 and 1 capture channels, bit 2 compare, read only); 1 enables (bits 2:0, read/write); 2/3 compare high/low (read/write); 4/5 counter high/low; 8/9 capture 0 high/low; 10/11 capture 1 high/low. `rdata_o` is valid in the same cycle as `rd_i` and is zero when `rd_i` is low. At most one access is made per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data, combinational from address |
| cap_i | input | 2 | Capture pins, rising-edge sensitive |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Two functions can land in the same clock: an incoming capture edge and the low-byte access that clears that channel's flag. The bench provokes this by raising the capture pin in the same cycle it issues the low-byte read, after an earlier status read has armed the clear. It then judges the outcome: the interrupt must still be asserted, and a new handshake must return the newer sample. A related race is an edge that falls between the high and low byte reads. For this case the bench checks that the low byte still comes from the older sample and that the flag survives.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned N_CAP  = 2;
  localparam int unsigned N_FLAG = N_CAP + 1;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CMP_BIT = N_CAP;

  localparam logic [ADDR_W-1:0] A_STAT     = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN      = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP_HI   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd5;
  localparam logic [ADDR_W-1:0] A_CAP_BASE = 4'd8;
endpackage

// File: rtl/capcmp_flag.sv
module capcmp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_acc_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      // a fresh event wins and voids any pending clear
      flag_o  <= 1'b1;
      armed_q <= 1'b0;
    end else if (stat_rd_i && flag_o) begin
      armed_q <= 1'b1;
    end else if (clr_acc_i && armed_q) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R7
  AST_CLR_ON_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(clr_acc_i)); // R5
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture
  import capcmp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hi_rd_i,
  output logic             event_o,
  output logic [CNT_W-1:0] val_o,
  output logic [BYTE_W-1:0] lo_o
);
  logic pin_q;

  assign event_o = pin_i & ~pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      val_o <= '0;
      lo_o  <= '0;
    end else begin
      pin_q <= pin_i;
      if (event_o) val_o <= cnt_i;
      if (hi_rd_i) lo_o  <= val_o[BYTE_W-1:0];
    end
  end

  AST_CAP_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> (val_o == $past(cnt_i))); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_rd_i |=> $stable(lo_o)); // R4
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare
  import capcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o <= '0;
      en_q  <= 1'b0;
    end else if (wr_hi_i) begin
      cmp_o[CNT_W-1:BYTE_W] <= wdata_i;
      en_q <= 1'b0;
    end else if (wr_lo_i) begin
      cmp_o[BYTE_W-1:0] <= wdata_i;
      en_q <= 1'b1;
    end
  end

  assign match_o = en_q && (cnt_i == cmp_o);

  AST_HI_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> !match_o); // R9
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [N_CAP-1:0]  cap_i,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] cnt_lo_q;
  logic [N_FLAG-1:0] ien_q;
  logic [N_FLAG-1:0] flag;
  logic [N_FLAG-1:0] set_ev;
  logic [N_FLAG-1:0] clr_acc;
  logic [CNT_W-1:0]  cmp_val;
  logic              stat_rd;

  logic [CNT_W-1:0]  cap_val [N_CAP];
  logic [BYTE_W-1:0] cap_lo  [N_CAP];

  assign stat_rd = rd_i && (addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      cnt_lo_q <= '0;
      ien_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rd_i && addr_i == A_CNT_HI) cnt_lo_q <= cnt_q[BYTE_W-1:0];
      if (wr_i && addr_i == A_IEN)    ien_q    <= wdata_i[N_FLAG-1:0];
    end
  end

  for (genvar n = 0; n < N_CAP; n++) begin : g_cap
    localparam logic [ADDR_W-1:0] HI_A = A_CAP_BASE + ADDR_W'(2 * n);
    localparam logic [ADDR_W-1:0] LO_A = HI_A + 1'b1;

    capcmp_capture u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (cap_i[n]),
      .cnt_i   (cnt_q),
      .hi_rd_i (rd_i && addr_i == HI_A),
      .event_o (set_ev[n]),
      .val_o   (cap_val[n]),
      .lo_o    (cap_lo[n])
    );
    assign clr_acc[n] = rd_i && (addr_i == LO_A);
  end

  capcmp_compare u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hi_i (wr_i && addr_i == A_CMP_HI),
    .wr_lo_i (wr_i && addr_i == A_CMP_LO),
    .wdata_i (wdata_i),
    .cnt_i   (cnt_q),
    .cmp_o   (cmp_val),
    .match_o (set_ev[CMP_BIT])
  );
  assign clr_acc[CMP_BIT] = wr_i && (addr_i == A_CMP_LO);

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    capcmp_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_ev[f]),
      .stat_rd_i (stat_rd),
      .clr_acc_i (clr_acc[f]),
      .flag_o    (flag[f])
    );
  end

  assign irq_o = |(flag & ien_q);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_STAT:   rdata_o = BYTE_W'(flag);
        A_IEN:    rdata_o = BYTE_W'(ien_q);
        A_CMP_HI: rdata_o = cmp_val[CNT_W-1:BYTE_W];
        A_CMP_LO: rdata_o = cmp_val[BYTE_W-1:0];
        A_CNT_HI: rdata_o = cnt_q[CNT_W-1:BYTE_W];
        A_CNT_LO: rdata_o = cnt_lo_q;
        default: begin
          for (int n = 0; n < N_CAP; n++) begin
            if (addr_i == A_CAP_BASE + ADDR_W'(2 * n))
              rdata_o = cap_val[n][CNT_W-1:BYTE_W];
            if (addr_i == A_CAP_BASE + ADDR_W'(2 * n + 1))
              rdata_o = cap_lo[n];
          end
        end
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i)); // R11
endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  localparam time HALF = 2.5ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [1:0] cap = '0;
  logic       irq;

  int tests = 0, fails = 0;
  logic [15:0] tb_cnt;

  always #HALF clk = ~clk;

  capcmp_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .cap_i(cap), .irq_o(irq)
  );

  // reference cycle count since reset release
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cnt <= '0; else tb_cnt <= tb_cnt + 16'd1;

  function automatic logic [3:0] cap_hi_a(int ch); return 4'(8 + 2*ch); endfunction
  function automatic logic [3:0] cap_lo_a(int ch); return 4'(9 + 2*ch); endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch, output logic [15:0] e);
    cap[ch] = 1'b1; e = tb_cnt;
    @(negedge clk); cap[ch] = 1'b0;
  endtask

  // full handshake: status, high byte, low byte; checks sample and release
  task automatic drain(int ch, logic [15:0] e, string req);
    logic [7:0] d;
    bus_rd(4'd0, d); chk(req, 16'(d[ch]), 16'd1);
    bus_rd(cap_hi_a(ch), d); chk(req, 16'(d), 16'(e[15:8]));
    bus_rd(cap_lo_a(ch), d); chk(req, 16'(d), 16'(e[7:0]));
    bus_rd(4'd0, d); chk(req, 16'(d[ch]), 16'd0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] e1, e2, t, v;
    void'($urandom(32'd5150));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'd0, d); chk("R1 status", 16'(d), 16'd0);
    bus_rd(4'd1, d); chk("R1 ien", 16'(d), 16'd0);
    chk("R1 irq", 16'(irq), 16'd0);
    idle(5);
    bus_rd(4'd0, d); chk("R1 cmp disabled", 16'(d), 16'd0);

    // R2 counter coherent read
    t = tb_cnt;
    bus_rd(4'd4, d); chk("R2 cnt hi", 16'(d), 16'(t[15:8]));
    bus_rd(4'd5, d); chk("R2 cnt lo frozen", 16'(d), 16'(t[7:0]));

    // R11 enable register
    bus_wr(4'd1, 8'h07);
    bus_rd(4'd1, d); chk("R11 ien readback", 16'(d), 16'h7);

    // R3 capture on each channel
    for (int ch = 0; ch < 2; ch++) begin
      idle(3 + ch);
      pulse(ch, e1);
      chk("R3 irq", 16'(irq), 16'd1);
      drain(ch, e1, "R3");
      chk("R3 irq released", 16'(irq), 16'd0);
    end

    // R5 low access without status read does not clear
    pulse(0, e1);
    bus_rd(cap_hi_a(0), d);
    bus_rd(cap_lo_a(0), d);
    chk("R5 no clear w/o status", 16'(irq), 16'd1);
    drain(0, e1, "R5");

    // R4 shadow keeps old sample, R6 flag survives
    idle(2);
    pulse(1, e1);
    bus_rd(4'd0, d);
    bus_rd(cap_hi_a(1), d); chk("R4 hi", 16'(d), 16'(e1[15:8]));
    idle(3);
    pulse(1, e2);
    bus_rd(cap_lo_a(1), d); chk("R4 lo old sample", 16'(d), 16'(e1[7:0]));
    chk("R6 flag kept", 16'(irq), 16'd1);
    drain(1, e2, "R6");

    // R7 event and clearing access in the same clock
    pulse(0, e1);
    bus_rd(4'd0, d);
    bus_rd(cap_hi_a(0), d);
    idle(2);
    cap[0] = 1'b1; e2 = tb_cnt;
    bus_rd(cap_lo_a(0), d);
    cap[0] = 1'b0;
    chk("R7 flag kept", 16'(irq), 16'd1);
    drain(0, e2, "R7");

    // R10 enable masking
    pulse(1, e1);
    bus_wr(4'd1, 8'h01); chk("R10 masked", 16'(irq), 16'd0);
    bus_wr(4'd1, 8'h02); chk("R10 enabled", 16'(irq), 16'd1);
    bus_wr(4'd1, 8'h07);
    drain(1, e1, "R10");

    // R8 compare timing
    v = tb_cnt + 16'd40;
    bus_wr(4'd2, v[15:8]);
    bus_wr(4'd3, v[7:0]);
    bus_rd(4'd2, d); chk("R11 cmp hi", 16'(d), 16'(v[15:8]));
    bus_rd(4'd3, d); chk("R11 cmp lo", 16'(d), 16'(v[7:0]));
    while (tb_cnt != v) @(negedge clk);
    chk("R8 not early", 16'(irq), 16'd0);
    @(negedge clk);
    chk("R8 at match", 16'(irq), 16'd1);
    bus_wr(4'd3, v[7:0]);
    chk("R5 cmp no clear w/o status", 16'(irq), 16'd1);
    bus_rd(4'd0, d); chk("R8 status bit2", 16'(d[2]), 16'd1);
    bus_wr(4'd3, v[7:0]);
    chk("R5 cmp cleared", 16'(irq), 16'd0);

    // R9 high write inhibits until low write
    v = tb_cnt + 16'd40;
    bus_wr(4'd2, v[15:8]);
    bus_wr(4'd3, v[7:0]);
    bus_wr(4'd2, v[15:8]);
    while (tb_cnt != v + 16'd3) @(negedge clk);
    chk("R9 inhibited", 16'(irq), 16'd0);
    v = tb_cnt + 16'd20;
    bus_wr(4'd2, v[15:8]);
    bus_wr(4'd3, v[7:0]);
    while (tb_cnt != v + 16'd1) @(negedge clk);
    chk("R9 re-enabled", 16'(irq), 16'd1);
    bus_rd(4'd0, d);
    bus_wr(4'd3, v[7:0]);
    chk("R9 cleared", 16'(irq), 16'd0);

    // random captures, compare masked
    bus_wr(4'd1, 8'h03);
    for (int i = 0; i < 40; i++) begin
      int ch;
      ch = int'($urandom % 2);
      idle(int'($urandom % 16));
      pulse(ch, e1);
      idle(1 + int'($urandom % 5));
      chk("R3 random irq", 16'(irq), 16'd1);
      drain(ch, e1, "R3 random");
      chk("R5 random release", 16'(irq), 16'd0);
    end

    finish_run();
  end
endmodule